// File: doc/BRIEF.md
# Scan Chain Structural Test Sequencer

This block runs one complete structural test on a single scan chain and the combinational logic that feeds it. A one-cycle start pulse latches five operands: the flush pattern, the state to preload, the stimulus for the primary inputs, the expected captured response and the command itself. The block then drives the chain's mode-select line, its serial data input and its clock enable through a fixed procedure. First it checks the chain as a plain shift register. Next it preloads the state. It then returns the chain to functional mode for one capture clock with the stimulus applied. Finally it unloads the captured response and compares it with the expected word.

Two sticky verdicts report the result: one for the shift check and one for the captured response. Both are held until the next accepted start. A one-cycle done pulse closes every run. The chain interface works in lockstep with the chain clock enable and has no back-pressure. The chain advances on exactly the cycles in which the enable is high, and the block samples the serial output on those same clock edges. If the shift check fails, the run stops before any preload.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After reset, scan_mode, chain_clk_en, done, shift_fail and resp_fail are 0, and pi_out is all zero.
- R2: start is acted on only while the block is idle. A start seen during a run, including in the cycle that done is high, changes neither the run's timing nor its pulse counts.
- R3: The shift check drives scan_mode high for CHAIN_LEN+8 enable pulses and sends flush_pat out on scan_si least significant bit first. On pulses CHAIN_LEN through CHAIN_LEN+7, counting from 0, scan_so must equal flush_pat bits 0 to 7 in order. Any mismatch, including one on the final pulse, sets shift_fail.
- R4: A failed shift check goes straight to done, with CHAIN_LEN+8 enable pulses in total, no capture and resp_fail 0. shift_fail and resp_fail are never both 1.
- R5: After a passing shift check, CHAIN_LEN more shift pulses send load_state most significant bit first, so that chain stage i holds load_state bit i. Stage CHAIN_LEN-1 drives scan_so, and scan_si enters stage 0.
- R6: The block then holds scan_mode low with the enable low for one cycle while pi_out carries the stimulus. It then issues exactly one enable pulse with scan_mode low (the capture), with the stimulus still on pi_out.
- R7: The unload drives scan_mode high for CHAIN_LEN pulses with scan_si at 0. It compares scan_so on each pulse with expected bit CHAIN_LEN-1 first, down to bit 0. Any mismatch sets resp_fail, which stays set for the rest of the run.
- R8: done is high for exactly one cycle. On a full run it comes 3*CHAIN_LEN+10 cycles after the start edge, and on a failed shift check it comes CHAIN_LEN+8 cycles after. The verdicts hold after done and are cleared by the next accepted start.
- R9: pi_out is all zero whenever scan_mode is high and while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run command, taken only when idle |
| flush_pat | input | CHAIN_LEN+8 | Shift-check pattern, bit 0 sent first |
| load_state | input | CHAIN_LEN | State to preload, bit i ends in stage i |
| stimulus | input | STIM_W | Primary-input pattern for the capture |
| expected | input | CHAIN_LEN | Expected captured state, bit i for stage i |
| scan_mode | output | 1 | 1 = shift-register mode, 0 = functional mode |
| scan_si | output | 1 | Serial data into stage 0 |
| chain_clk_en | output | 1 | Chain clock enable, one pulse per shift or capture |
| pi_out | output | STIM_W | Stimulus to the logic under test |
| scan_so | input | 1 | Serial data out of the last stage |
| done | output | 1 | One-cycle end-of-run pulse |
| shift_fail | output | 1 | Sticky shift-check verdict |
| resp_fail | output | 1 | Sticky response verdict |

## Verification
Two functions can fall in the same cycle. The last comparison of the shift check can coincide with the decision whether to go on to the preload, and an incoming start can coincide with the done pulse. The bench inverts scan_so only on the final shift-check pulse. It then requires shift_fail to be set and the pulse total to stop at CHAIN_LEN+8, with no capture. It also raises start in the done cycle and in the middle of a run. It then requires the enable pulse count, the done timing and the idle quiet period to stay exactly as for an undisturbed run.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int unsigned CHK_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHIFT_CHECK,
    PH_LOAD,
    PH_APPLY,
    PH_CAPTURE,
    PH_UNLOAD,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          shift_bad,
  output phase_e        phase,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CHK_LAST = CW'(CHAIN_LEN + CHK_W - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(CHAIN_LEN - 1);

  phase_e        phase_nxt;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    phase_nxt = phase;
    cnt_nxt   = cnt + 1'b1;
    case (phase)
      PH_IDLE: begin
        cnt_nxt = '0;
        if (accept) phase_nxt = PH_SHIFT_CHECK;
      end
      PH_SHIFT_CHECK: begin
        if (cnt == CHK_LAST) begin
          cnt_nxt   = '0;
          phase_nxt = shift_bad ? PH_DONE : PH_LOAD;
        end
      end
      PH_LOAD: begin
        if (cnt == LEN_LAST) begin
          cnt_nxt   = '0;
          phase_nxt = PH_APPLY;
        end
      end
      PH_APPLY: begin
        cnt_nxt   = '0;
        phase_nxt = PH_CAPTURE;
      end
      PH_CAPTURE: begin
        cnt_nxt   = '0;
        phase_nxt = PH_UNLOAD;
      end
      PH_UNLOAD: begin
        if (cnt == LEN_LAST) begin
          cnt_nxt   = '0;
          phase_nxt = PH_DONE;
        end
      end
      PH_DONE: begin
        cnt_nxt   = '0;
        phase_nxt = PH_IDLE;
      end
      default: begin
        cnt_nxt   = '0;
        phase_nxt = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/scan_seq_path.sv
module scan_seq_path
  import scan_seq_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned STIM_W = 8,
  parameter int unsigned CW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  phase_e                     phase,
  input  logic [CW-1:0]              cnt,
  input  logic [CHAIN_LEN+CHK_W-1:0] flush_pat,
  input  logic [CHAIN_LEN-1:0]       load_state,
  input  logic [STIM_W-1:0]          stimulus,
  input  logic [CHAIN_LEN-1:0]       expected,
  output logic                       scan_mode,
  output logic                       scan_si,
  output logic                       chain_clk_en,
  output logic [STIM_W-1:0]          pi_out,
  output logic                       chk_valid,
  output logic                       chk_bit,
  output logic                       resp_valid,
  output logic                       resp_bit
);
  localparam int unsigned FW = CHAIN_LEN + CHK_W;
  localparam logic [CW-1:0] LEN_C = CW'(CHAIN_LEN);

  logic [FW-1:0]        flush_q;
  logic [CHK_W-1:0]     ref_q;
  logic [CHAIN_LEN-1:0] load_q;
  logic [CHAIN_LEN-1:0] exp_q;
  logic [STIM_W-1:0]    stim_q;
  logic                 cmp_on;

  assign cmp_on = (phase == PH_SHIFT_CHECK) && (cnt >= LEN_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= '0;
      ref_q   <= '0;
      load_q  <= '0;
      exp_q   <= '0;
      stim_q  <= '0;
    end else if (accept) begin
      flush_q <= flush_pat;
      ref_q   <= flush_pat[CHK_W-1:0];
      load_q  <= load_state;
      exp_q   <= expected;
      stim_q  <= stimulus;
    end else begin
      case (phase)
        PH_SHIFT_CHECK: begin
          flush_q <= flush_q >> 1;
          if (cmp_on) ref_q <= ref_q >> 1;
        end
        PH_LOAD:   load_q <= load_q << 1;
        PH_UNLOAD: exp_q  <= exp_q << 1;
        default: ;
      endcase
    end
  end

  always_comb begin
    scan_mode    = (phase == PH_SHIFT_CHECK) || (phase == PH_LOAD) ||
                   (phase == PH_UNLOAD);
    chain_clk_en = scan_mode || (phase == PH_CAPTURE);
    case (phase)
      PH_SHIFT_CHECK: scan_si = flush_q[0];
      PH_LOAD:        scan_si = load_q[CHAIN_LEN-1];
      default:        scan_si = 1'b0;
    endcase
    pi_out     = ((phase == PH_APPLY) || (phase == PH_CAPTURE)) ? stim_q : '0;
    chk_valid  = cmp_on;
    chk_bit    = ref_q[0];
    resp_valid = (phase == PH_UNLOAD);
    resp_bit   = exp_q[CHAIN_LEN-1];
  end
endmodule

// File: rtl/scan_seq_judge.sv
module scan_seq_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scan_so,
  input  logic chk_valid,
  input  logic chk_bit,
  input  logic resp_valid,
  input  logic resp_bit,
  output logic shift_fail,
  output logic resp_fail,
  output logic shift_bad
);
  logic chk_miss;
  logic resp_miss;

  assign chk_miss  = chk_valid && (scan_so != chk_bit);
  assign resp_miss = resp_valid && (scan_so != resp_bit);
  assign shift_bad = shift_fail || chk_miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_fail <= 1'b0;
      resp_fail  <= 1'b0;
    end else if (clr) begin
      shift_fail <= 1'b0;
      resp_fail  <= 1'b0;
    end else begin
      if (chk_miss)  shift_fail <= 1'b1;
      if (resp_miss) resp_fail  <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned STIM_W = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    start,
  input  logic [CHAIN_LEN+scan_seq_pkg::CHK_W-1:0] flush_pat,
  input  logic [CHAIN_LEN-1:0]                    load_state,
  input  logic [STIM_W-1:0]                       stimulus,
  input  logic [CHAIN_LEN-1:0]                    expected,
  output logic                                    scan_mode,
  output logic                                    scan_si,
  output logic                                    chain_clk_en,
  output logic [STIM_W-1:0]                       pi_out,
  input  logic                                    scan_so,
  output logic                                    done,
  output logic                                    shift_fail,
  output logic                                    resp_fail
);
  localparam int unsigned CW = $clog2(CHAIN_LEN + CHK_W + 1);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          shift_bad;
  logic          chk_valid;
  logic          chk_bit;
  logic          resp_valid;
  logic          resp_bit;

  assign accept = start && (phase == PH_IDLE);
  assign done   = (phase == PH_DONE);

  scan_seq_fsm #(.CHAIN_LEN(CHAIN_LEN), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .shift_bad (shift_bad),
    .phase     (phase),
    .cnt       (cnt)
  );

  scan_seq_path #(.CHAIN_LEN(CHAIN_LEN), .STIM_W(STIM_W), .CW(CW)) u_path (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .phase        (phase),
    .cnt          (cnt),
    .flush_pat    (flush_pat),
    .load_state   (load_state),
    .stimulus     (stimulus),
    .expected     (expected),
    .scan_mode    (scan_mode),
    .scan_si      (scan_si),
    .chain_clk_en (chain_clk_en),
    .pi_out       (pi_out),
    .chk_valid    (chk_valid),
    .chk_bit      (chk_bit),
    .resp_valid   (resp_valid),
    .resp_bit     (resp_bit)
  );

  scan_seq_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (accept),
    .scan_so    (scan_so),
    .chk_valid  (chk_valid),
    .chk_bit    (chk_bit),
    .resp_valid (resp_valid),
    .resp_bit   (resp_bit),
    .shift_fail (shift_fail),
    .resp_fail  (resp_fail),
    .shift_bad  (shift_bad)
  );
endmodule

// File: rtl/scan_seq_ctrl_chk.sv
module scan_seq_ctrl_chk #(
  parameter int unsigned STIM_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              scan_mode,
  input logic              chain_clk_en,
  input logic [STIM_W-1:0] pi_out,
  input logic              done,
  input logic              shift_fail,
  input logic              resp_fail
);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!shift_fail && !resp_fail));

  assert_start_shifts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (scan_mode && chain_clk_en));

  assert_capture_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_clk_en && !scan_mode) |=> (chain_clk_en && scan_mode));

  assert_pi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_out != '0) |-> !scan_mode);

  assert_shift_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fail && !accept) |=> shift_fail);

  assert_resp_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_fail && !accept) |=> resp_fail);

  assert_fail_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_fail && resp_fail));
endmodule

bind scan_seq_ctrl scan_seq_ctrl_chk #(.STIM_W(STIM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (accept),
  .scan_mode    (scan_mode),
  .chain_clk_en (chain_clk_en),
  .pi_out       (pi_out),
  .done         (done),
  .shift_fail   (shift_fail),
  .resp_fail    (resp_fail)
);

// File: tb/scan_seq_ctrl_test.sv
`timescale 1ns/1ps
module scan_seq_ctrl_test;
  localparam int L = 16;
  localparam int S = 8;
  localparam int FW = L + 8;
  localparam int HW = 3 * L + 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] flush_pat = '0;
  logic [L-1:0]  load_state = '0;
  logic [S-1:0]  stimulus = '0;
  logic [L-1:0]  expected = '0;
  logic scan_mode, scan_si, chain_clk_en, scan_so, done, shift_fail, resp_fail;
  logic [S-1:0] pi_out;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  scan_seq_ctrl #(.CHAIN_LEN(L), .STIM_W(S)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .flush_pat(flush_pat),
    .load_state(load_state), .stimulus(stimulus), .expected(expected),
    .scan_mode(scan_mode), .scan_si(scan_si), .chain_clk_en(chain_clk_en),
    .pi_out(pi_out), .scan_so(scan_so), .done(done),
    .shift_fail(shift_fail), .resp_fail(resp_fail));

  // behavioural chain plus logic under test
  function automatic logic [L-1:0] cap_fn(input logic [L-1:0] s, input logic [S-1:0] p);
    logic [L-1:0] r;
    for (int i = 0; i < L; i++)
      r[i] = s[(i + L - 1) % L] ^ p[i % S] ^ (s[i] & i[0]);
    return r;
  endfunction

  logic [L-1:0] chain = '0;
  logic stuck = 1'b0;
  logic arm_flip = 1'b0;
  int   flip_at = -1;
  int   en_total = 0;
  int   cap_total = 0;
  int   pi_bad = 0;
  logic [L-1:0] pre_cap = '0;
  logic [S-1:0] pi_cap = '0;
  logic [HW-1:0] hist = '0;

  assign scan_so = stuck ? 1'b0 :
                   (chain[L-1] ^ (arm_flip && scan_mode && (en_total == flip_at)));

  always @(posedge clk) begin
    if (chain_clk_en) begin
      if (scan_mode) chain <= {chain[L-2:0], scan_si};
      else           chain <= cap_fn(chain, pi_out);
    end
  end

  always @(negedge clk) begin
    if (chain_clk_en) begin
      en_total <= en_total + 1;
      hist <= {scan_si, hist[HW-1:1]};
      if (!scan_mode) begin
        cap_total <= cap_total + 1;
        pre_cap <= chain;
        pi_cap <= pi_out;
      end
    end
    if (scan_mode && pi_out != '0) pi_bad <= pi_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // run one sequence; returns cycles to done and pulse counts
  int r_cyc, r_en, r_cap, r_pi;
  task automatic run(input logic [FW-1:0] f, input logic [L-1:0] ld,
                     input logic [S-1:0] st, input logic [L-1:0] ex,
                     input int mid_start);
    int e0, c0, p0;
    @(negedge clk);
    flush_pat = f; load_state = ld; stimulus = st; expected = ex;
    e0 = en_total; c0 = cap_total; p0 = pi_bad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_cyc = 0;
    while (!done && r_cyc < 1000) begin
      if (mid_start > 0 && r_cyc == mid_start) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      r_cyc++;
    end
    start = 1'b0;
    r_en = en_total - e0;
    r_cap = cap_total - c0;
    r_pi = pi_bad - p0;
  endtask

  function automatic logic [L-1:0] rev(input logic [L-1:0] v);
    logic [L-1:0] r;
    for (int i = 0; i < L; i++) r[i] = v[L-1-i];
    return r;
  endfunction

  task automatic t_reset();
    chk(scan_mode == 0 && chain_clk_en == 0, "R1", "mode/enable after reset",
        {scan_mode, chain_clk_en}, 0);
    chk(done == 0 && shift_fail == 0 && resp_fail == 0, "R1", "status after reset",
        {done, shift_fail, resp_fail}, 0);
    chk(pi_out == 0, "R1", "pi_out after reset", pi_out, 0);
  endtask

  task automatic t_pass(input logic [FW-1:0] f, input logic [L-1:0] ld,
                        input logic [S-1:0] st);
    logic [L-1:0] resp;
    resp = cap_fn(ld, st);
    run(f, ld, st, resp, 0);
    chk(r_cyc == 3*L+10, "R8", "done latency", r_cyc, 3*L+10);
    chk(shift_fail == 0 && resp_fail == 0, "R7", "verdicts on good run",
        {shift_fail, resp_fail}, 0);
    chk(r_en == 3*L+9, "R3", "total enable pulses", r_en, 3*L+9);
    chk(hist[FW-1:0] == f, "R3", "flush bits on scan_si", hist[FW-1:0], f);
    chk(hist[2*L+7:L+8] == rev(ld), "R5", "load bits MSB first", hist[2*L+7:L+8], rev(ld));
    chk(pre_cap == ld, "R5", "chain state before capture", pre_cap, ld);
    chk(r_cap == 1, "R6", "capture pulses", r_cap, 1);
    chk(pi_cap == st, "R6", "stimulus at capture", pi_cap, st);
    chk(hist[HW-1:2*L+9] == 0, "R7", "scan_si during unload", hist[HW-1:2*L+9], 0);
    chk(r_pi == 0, "R9", "pi_out while shifting", r_pi, 0);
    @(negedge clk);
    chk(done == 0, "R8", "done lasts one cycle", done, 0);
    chk(pi_out == 0, "R9", "pi_out when idle", pi_out, 0);
  endtask

  task automatic t_resp_miss();
    logic [L-1:0] resp;
    resp = cap_fn(16'h5A3C, 8'h96);
    run(24'hC3_A55A, 16'h5A3C, 8'h96, resp ^ (16'h1 << (L-1)), 0);
    chk(resp_fail == 1 && shift_fail == 0, "R7", "wrong expected MSB",
        {shift_fail, resp_fail}, 1);
    repeat (4) @(negedge clk);
    chk(resp_fail == 1, "R8", "verdict held when idle", resp_fail, 1);
    resp = cap_fn(16'h0F0F, 8'h3C);
    run(24'h5A_1234, 16'h0F0F, 8'h3C, resp ^ 16'h1, 0);
    chk(resp_fail == 1, "R7", "wrong expected LSB", resp_fail, 1);
    t_pass(24'h81_FFFF, 16'hFFFF, 8'h01);
    chk(resp_fail == 0, "R8", "verdict cleared by start", resp_fail, 1'b0);
  endtask

  task automatic t_stuck();
    stuck = 1'b1;
    run(24'h00_00A7, 16'h1234, 8'h55, 16'h0, 0);
    stuck = 1'b0;
    chk(shift_fail == 1, "R3", "stuck scan_so detected", shift_fail, 1);
    chk(resp_fail == 0, "R4", "no response verdict", resp_fail, 0);
    chk(r_en == L+8, "R4", "pulses on failed check", r_en, L+8);
    chk(r_cap == 0, "R4", "no capture on failed check", r_cap, 0);
    chk(r_cyc == L+8, "R8", "done latency on failed check", r_cyc, L+8);
  endtask

  task automatic t_last_bit();
    logic [L-1:0] resp;
    resp = cap_fn(16'hBEEF, 8'h42);
    flip_at = en_total + L + 8;
    arm_flip = 1'b1;
    run(24'h6D_C0DE, 16'hBEEF, 8'h42, resp, 0);
    arm_flip = 1'b0;
    chk(shift_fail == 1, "R3", "mismatch on final compare", shift_fail, 1);
    chk(r_en == L+8 && r_cap == 0, "R4", "stop after final compare", r_en, L+8);
  endtask

  task automatic t_start_ignored();
    logic [L-1:0] resp;
    int e0;
    resp = cap_fn(16'h8001, 8'hF0);
    run(24'h3E_7711, 16'h8001, 8'hF0, resp, 7);
    chk(r_cyc == 3*L+10, "R2", "start mid-run: latency", r_cyc, 3*L+10);
    chk(r_en == 3*L+9, "R2", "start mid-run: pulses", r_en, 3*L+9);
    // start raised in the done cycle
    start = 1'b1;
    e0 = en_total;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(en_total == e0, "R2", "start at done ignored", en_total - e0, 0);
    chk(done == 0 && scan_mode == 0, "R2", "still idle", {done, scan_mode}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pass(24'hA5_1E2D, 16'hC35A, 8'h9B);
    t_pass(24'h0F_FFFF, 16'h0001, 8'h00);
    t_resp_miss();
    t_stuck();
    t_last_bit();
    t_pass(24'h72_4411, 16'h7E81, 8'hAA);
    t_start_ignored();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule